// File: doc/BRIEF.md
# Serial-Controlled Eight-Channel Mixer Register Bank

This block is the digital control core of an eight-input, two-output audio mixer. A host loads it over a slow serial slave port made of a serial clock, a data line, an active-low write enable and an active-low load strobe. Every byte that is shifted in and then committed is decoded by its top bit. A byte with the top bit set selects a channel and sets that channel's left and right routing. A byte with the top bit clear loads a 6-bit attenuation code into whichever channel was selected last. The selection persists, so a channel can be faded by sending a run of data bytes alone.

The serial pins are oversampled in the system clock domain: each one passes through a synchronizer, and the block acts on the edges it detects. The top bit of the shift register is driven out on a serial data output, so a second device can sit downstream on the same strobes. With write and load tied together the port behaves as a plain three-wire interface. With them driven apart, several devices can be filled first and then committed on one shared load edge. An active-high mute input forces every routing enable low at once, without waiting for a clock, and clears the stored routing. The attenuation codes are left as they are, so an address byte sent after the mute returns a channel at its old level.

Top module: `mixer_ctl`

## Requirements
- R1: On each detected rising edge of `ser_clk` while `ser_wr_n` is low, the 8-bit shift register moves one place toward its top bit and takes `ser_din` into bit 0, so a byte arrives MSB first.
- R2: Shifting alone never changes `atten_o`, `route_l_o` or `route_r_o`; the held byte is committed only on a detected rising edge of `ser_ld_n`.
- R3: A committed byte with bit 7 = 1 is an address byte. Bits 2..0 select the channel, bit 4 becomes that channel's left enable and bit 3 becomes its right enable. The routing of the other channels is unchanged.
- R4: A committed byte with bit 7 = 0 is a data byte. Bits 5..0 become the attenuation code of the selected channel (0 = no attenuation, 63 = most attenuation), and the other channels are unchanged. Channel c appears at `atten_o[6c+5:6c]`.
- R5: The channel selection persists, so consecutive data bytes with no address byte between them all update the same channel.
- R6: `ser_dout` always equals the top bit of the shift register. After 8 further shifts it carries the first bit of the earlier byte, which lets two devices be chained over 16 clocks.
- R7: While `mute` is high, every bit of `route_l_o` and `route_r_o` is 0, with no clock edge needed. The stored routing is cleared, so routing stays off after `mute` falls until a new address byte is committed.
- R8: `mute` never changes the stored attenuation codes. An address byte committed after `mute` falls brings its channel back at the code it held before.
- R9: While `rst` is high, all attenuation codes, all routing enables, the channel selection and the shift register become 0.
- R10: A rising edge of `ser_ld_n` with no serial clocks before it commits again whatever byte the shift register already holds.
- R11: Rising edges of `ser_clk` while `ser_wr_n` is high leave the shift register and `ser_dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock; acts on its rising edges |
| ser_din | input | 1 | Serial data input, MSB first |
| ser_wr_n | input | 1 | Active-low write enable; shifting is allowed only while it is low |
| ser_ld_n | input | 1 | Active-low load strobe; its rising edge commits the held byte |
| mute | input | 1 | Active-high system mute |
| ser_dout | output | 1 | Top bit of the shift register, used for chaining |
| atten_o | output | 48 | Eight 6-bit attenuation codes; channel c in bits 6c+5..6c |
| route_l_o | output | 8 | Left output enable for each channel, gated by mute |
| route_r_o | output | 8 | Right output enable for each channel, gated by mute |

## Verification
A wrong channel selection does not show until the next data byte is committed: that byte lands in the wrong slice of `atten_o` and leaves the intended slice as it was, a few system cycles after the load edge. A wrong shift register shows sooner, on `ser_dout` one edge later and again eight edges later when the bad bit reaches the top. It also shows as a misdecoded byte on the next commit. Routing that survives a mute shows only after the mute is released, either as an enable that reappears with no address byte or as an enable that a load-only recommit fails to restore. The bench therefore checks every output after every byte, every shift of a chained stream, and each step around the mute.

// File: rtl/mixer_ctl_pkg.sv
package mixer_ctl_pkg;
  // Fields of a committed command byte; the decoder depends on these positions.
  localparam int unsigned CMD_KIND_BIT  = 7;  // 1: address byte, 0: data byte
  localparam int unsigned CMD_LEFT_BIT  = 4;
  localparam int unsigned CMD_RIGHT_BIT = 3;

  typedef enum logic {
    CMD_DATA = 1'b0,
    CMD_ADDR = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/mixer_sync.sv
module mixer_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mixer_serial_front.sv
module mixer_serial_front #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_wr_n,
  input  logic              ser_ld_n,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              commit_o,
  output logic              shift_en_o,
  output logic              dout_o
);
  // Synchronized pin order: {ld_n, wr_n, din, sclk}; strobes idle high.
  localparam logic [3:0] PIN_RST = 4'b1100;

  logic [3:0] pins_s;
  logic       sclk_prev_q, ld_prev_q;
  logic       sclk_rise, ld_rise;
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] cmd_q;
  logic              commit_q;

  mixer_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(PIN_RST)) pin_sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({ser_ld_n, ser_wr_n, ser_din, ser_clk}),
    .q   (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      ld_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= pins_s[0];
      ld_prev_q   <= pins_s[3];
    end
  end

  assign sclk_rise  = pins_s[0] & ~sclk_prev_q;
  assign ld_rise    = pins_s[3] & ~ld_prev_q;
  assign shift_en_o = sclk_rise & ~pins_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      cmd_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      if (shift_en_o) shift_q <= {shift_q[BYTE_W-2:0], pins_s[1]};
      commit_q <= ld_rise;
      if (ld_rise) cmd_q <= shift_q;
    end
  end

  assign cmd_o    = cmd_q;
  assign commit_o = commit_q;
  assign dout_o   = shift_q[BYTE_W-1];
endmodule

// File: rtl/mixer_reg_bank.sv
module mixer_reg_bank
  import mixer_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ATT_W  = 6,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit_i,
  input  logic [BYTE_W-1:0]       cmd_i,
  input  logic                    mute_s_i,
  output logic [NUM_CH*ATT_W-1:0] atten_o,
  output logic [NUM_CH-1:0]       left_q_o,
  output logic [NUM_CH-1:0]       right_q_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  cmd_kind_e         kind;
  logic [CH_W-1:0]   sel_q;
  logic [CH_W-1:0]   cmd_ch;
  logic              addr_stb, data_stb;

  assign kind     = cmd_kind_e'(cmd_i[CMD_KIND_BIT]);
  assign cmd_ch   = cmd_i[CH_W-1:0];
  assign addr_stb = commit_i & (kind == CMD_ADDR);
  assign data_stb = commit_i & (kind == CMD_DATA);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (addr_stb) sel_q <= cmd_ch;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ATT_W-1:0] att_q;
    logic             l_q, r_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        att_q <= '0;
      end else if (data_stb && sel_q == CH_W'(c)) begin
        att_q <= cmd_i[ATT_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst || mute_s_i) begin
        l_q <= 1'b0;
        r_q <= 1'b0;
      end else if (addr_stb && cmd_ch == CH_W'(c)) begin
        l_q <= cmd_i[CMD_LEFT_BIT];
        r_q <= cmd_i[CMD_RIGHT_BIT];
      end
    end

    assign atten_o[c*ATT_W +: ATT_W] = att_q;
    assign left_q_o[c]  = l_q;
    assign right_q_o[c] = r_q;
  end
endmodule

// File: rtl/mixer_ctl.sv
module mixer_ctl #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned ATT_W       = 6,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ser_clk,
  input  logic                    ser_din,
  input  logic                    ser_wr_n,
  input  logic                    ser_ld_n,
  input  logic                    mute,
  output logic                    ser_dout,
  output logic [NUM_CH*ATT_W-1:0] atten_o,
  output logic [NUM_CH-1:0]       route_l_o,
  output logic [NUM_CH-1:0]       route_r_o
);
  logic [BYTE_W-1:0] cmd;
  logic              commit;
  logic              shift_en;
  logic              mute_s;
  logic [NUM_CH-1:0] left_q, right_q;

  mixer_serial_front #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk        (clk),
    .rst        (rst),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .ser_wr_n   (ser_wr_n),
    .ser_ld_n   (ser_ld_n),
    .cmd_o      (cmd),
    .commit_o   (commit),
    .shift_en_o (shift_en),
    .dout_o     (ser_dout)
  );

  mixer_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) mute_sync_i (
    .clk (clk),
    .rst (rst),
    .d   (mute),
    .q   (mute_s)
  );

  mixer_reg_bank #(.NUM_CH(NUM_CH), .ATT_W(ATT_W), .BYTE_W(BYTE_W)) bank_i (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (commit),
    .cmd_i     (cmd),
    .mute_s_i  (mute_s),
    .atten_o   (atten_o),
    .left_q_o  (left_q),
    .right_q_o (right_q)
  );

  // Mute reaches the enables through gating alone, so it acts before any edge.
  assign route_l_o = left_q  & {NUM_CH{~mute}};
  assign route_r_o = right_q & {NUM_CH{~mute}};
endmodule

// File: rtl/mixer_ctl_chk.sv
module mixer_ctl_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ATT_W  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mute,
  input logic                    shift_en,
  input logic                    commit,
  input logic                    ser_dout,
  input logic [NUM_CH*ATT_W-1:0] atten_o,
  input logic [NUM_CH-1:0]       route_l_o,
  input logic [NUM_CH-1:0]       route_r_o
);
  // R7
  mute_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mute |-> (route_l_o == '0 && route_r_o == '0));

  // R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(ser_dout));

  // R2
  atten_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(atten_o));

  // R8
  mute_keeps_att_chk: assert property (@(posedge clk) disable iff (rst)
    (mute && !commit) |=> $stable(atten_o));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (atten_o == '0 && route_l_o == '0 && route_r_o == '0 && !ser_dout));
endmodule

bind mixer_ctl mixer_ctl_chk #(.NUM_CH(NUM_CH), .ATT_W(ATT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mute      (mute),
  .shift_en  (shift_en),
  .commit    (commit),
  .ser_dout  (ser_dout),
  .atten_o   (atten_o),
  .route_l_o (route_l_o),
  .route_r_o (route_r_o)
);

// File: tb/mixer_ctl_tb_top.sv
`timescale 1ns/1ps
module mixer_ctl_tb_top;
  localparam int NCH = 8;
  localparam int AW  = 6;
  localparam int H   = 6;   // system cycles per serial phase
  localparam int SET = 10;  // settle cycles after a strobe

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_wr_n = 1'b1, ser_ld_n = 1'b1, mute = 1'b0;
  logic ser_dout;
  logic [NCH*AW-1:0] atten_o;
  logic [NCH-1:0]    route_l_o, route_r_o;

  always #4 clk = ~clk;  // 125 MHz

  mixer_ctl dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_wr_n(ser_wr_n), .ser_ld_n(ser_ld_n), .mute(mute),
    .ser_dout(ser_dout), .atten_o(atten_o),
    .route_l_o(route_l_o), .route_r_o(route_r_o)
  );

  typedef struct {
    logic [NCH*AW-1:0] att;
    logic [NCH-1:0]    l, r;
    logic              dout;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model
  logic [AW-1:0]  m_att [NCH];
  logic [NCH-1:0] m_l = '0, m_r = '0;
  logic [2:0]     m_sel = '0;
  logic [7:0]     m_shift = '0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string req);
    exp_t e;
    for (int c = 0; c < NCH; c++) e.att[c*AW +: AW] = m_att[c];
    e.l = m_l; e.r = m_r; e.dout = m_shift[7]; e.req = req;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
    wait_n(1);
  endtask

  // Monitor: compares the oldest expectation at a falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "atten", 64'(atten_o), 64'(e.att));
        check(e.req, "left", 64'(route_l_o), 64'(e.l));
        check(e.req, "right", 64'(route_r_o), 64'(e.r));
        check(e.req, "dout", 64'(ser_dout), 64'(e.dout));
      end
    end
  end

  task automatic model_commit(input logic [7:0] b);
    if (b[7]) begin
      m_sel = b[2:0];
      if (!mute) begin
        m_l[b[2:0]] = b[4];
        m_r[b[2:0]] = b[3];
      end
    end else begin
      m_att[m_sel] = b[5:0];
    end
  endtask

  task automatic bit_clk(input logic b);
    ser_din = b;
    wait_n(H);
    ser_clk = 1'b1;
    wait_n(H);
    ser_clk = 1'b0;
    if (!ser_wr_n) m_shift = {m_shift[6:0], b};
    wait_n(H);
  endtask

  task automatic shift_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_clk(b[i]);
  endtask

  // Tied write/load strobe.
  task automatic send3(input logic [7:0] b, input string req);
    ser_wr_n = 1'b0; ser_ld_n = 1'b0;
    wait_n(H);
    shift_byte(b);
    ser_wr_n = 1'b1; ser_ld_n = 1'b1;
    wait_n(SET);
    model_commit(m_shift);
    push(req);
  endtask

  task automatic load_pulse(input string req);
    ser_ld_n = 1'b0;
    wait_n(H);
    ser_ld_n = 1'b1;
    wait_n(SET);
    model_commit(m_shift);
    push(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) m_att[c] = '0;
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    push("R9 reset state");

    // Address and data decoding
    send3(8'h98, "R3 ch0 left+right");
    send3(8'h15, "R4 ch0 code 21");
    send3(8'h3F, "R5 ch0 second data byte same channel");
    send3(8'h93, "R3 ch3 left only");
    send3(8'h2A, "R4 ch3 code 42, ch0 unchanged");
    send3(8'h8D, "R3 ch5 right only");
    send3(8'h07, "R5 ch5 code 7");
    send3(8'h00, "R4 ch5 code 0 boundary");

    // Separate write and load: shifting alone commits nothing
    ser_wr_n = 1'b0;
    wait_n(H);
    shift_byte(8'h8F);
    ser_wr_n = 1'b1;
    wait_n(SET);
    push("R2 shifted byte not yet committed; R1 dout is bit 7");
    load_pulse("R2 load edge commits ch7 right");

    // Clocks while write is high are ignored
    bit_clk(1'b0); bit_clk(1'b0); bit_clk(1'b1);
    push("R11 no shift while write high");

    // Mute
    wait_n(1);
    mute = 1'b1;
    #1;
    check("R7", "immediate left", 64'(route_l_o), 64'h0);
    check("R7", "immediate right", 64'(route_r_o), 64'h0);
    m_l = '0; m_r = '0;
    wait_n(SET);
    push("R8 attenuation kept during mute");
    mute = 1'b0;
    wait_n(SET);
    push("R7 routing stays off after mute release");
    load_pulse("R10 load-only recommit of held address byte");
    send3(8'h9B, "R8 ch3 back on both sides at code 42");

    // Chained stream: 16 bits with load held high
    ser_wr_n = 1'b0;
    wait_n(H);
    for (int k = 15; k >= 0; k--) begin
      bit_clk(k >= 8 ? 1'(8'hC3 >> (k - 8)) : 1'(8'h5A >> k));
      push("R6 dout follows top of shift register");
    end
    ser_wr_n = 1'b1;
    wait_n(SET);
    load_pulse("R6 chained second byte commits as data to ch3");

    wait_n(4);
    rst = 1'b1;
    wait_n(3);
    for (int c = 0; c < NCH; c++) m_att[c] = '0;
    m_l = '0; m_r = '0; m_sel = '0; m_shift = '0;
    rst = 1'b0;
    wait_n(2);
    push("R9 mid-run reset clears all");
    send3(8'h11, "R9 selection back to ch0 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule